// File: doc/BRIEF.md
# Windowed and Sequenced Watchdog Timer

This block is a supervision timer that has to be serviced at the right time and in the right way. A free-running counter advances on ticks from a programmable clock pre-divider. When it reaches a programmable terminal count it signals an overflow. Software keeps it alive through one of five refresh disciplines. In direct mode a refresh strobe is accepted at any time. In window mode the strobe counts only when it arrives late enough. In sequence mode software reads the live counter and echoes that exact value back as a timestamp within a bounded number of counter steps. Two combined modes join the sequence check with the direct or window discipline.

Configuration is held in eight word-wide registers behind a single-cycle write port and a combinational read port. A refresh that breaks the rules does not restart the counter. It sets a sticky status flag instead. Three flags (early window refresh, bad sequence refresh, overflow) each have an enable bit, and the interrupt output is raised whenever an enabled flag is set. The overflow is also exported as a one-cycle pulse for a reset controller next to the block.

Top module: `wdog_seqwin`

## Requirements
- R1: After reset the counter reads 0, every configuration register reads 0 (counter stopped, direct mode), all status flags are 0, and `ovf_o` and `irq_o` are low.
- R2: While the run bit (control register, address 0, bit 0) is set, the counter advances once every RATIO+1 clock cycles, where RATIO is the 16-bit value at address 1 (RATIO 0 advances every cycle). A successful refresh also clears the pre-divider phase.
- R3: When an advance would bring the counter to the terminal count (address 2), `ovf_o` pulses for one cycle and status bit 2 is set. If auto-restart (control bit 1) is set, the counter returns to 0, so overflows repeat every TERM*(RATIO+1) cycles.
- R4: With auto-restart clear, the counter stops at the terminal count after an overflow and produces no further overflow pulses until it is refreshed.
- R5: The mode field is control bits [4:2]: 0 direct, 1 window, 2 sequence, 3 direct plus sequence, 4 window plus sequence. Codes 5 to 7 behave as direct. In direct mode a high `kick_i` restarts the counter at 0, whatever its value.
- R6: In window mode a `kick_i` restarts the counter only if the counter is at least the window low limit (address 3) and no greater than the terminal count. A kick below the limit sets status bit 0 and leaves the counter running on.
- R7: A read of address 5 returns the live counter value and latches that value as the sequence snapshot.
- R8: In modes 2, 3 and 4 the refresh event is a write to address 5, and `kick_i` is ignored. The write restarts the counter when a snapshot is held, the written value equals the snapshot, and the counter minus the snapshot is below the sequence delta (address 4). Each write consumes the snapshot.
- R9: In a sequence mode, a timestamp write whose value differs from the snapshot sets status bit 1 and does not restart the counter.
- R10: In a sequence mode, a matching timestamp write that arrives once the counter has moved on by the delta or more sets status bit 1 and does not restart the counter. A write at delta minus one steps is legal.
- R11: In mode 4 a timestamp write must also pass the window check. A write that fails only the window check sets status bit 0 alone and does not restart the counter. In mode 3 no window check is made.
- R12: Status bits (address 7) stay set until a write of 1 to that bit at address 7. A set in the same cycle wins over the clear. `irq_o` is high exactly when a status bit and the matching enable bit (address 6) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kick_i | input | 1 | Refresh strobe, one cycle per refresh |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | CW | Register write data |
| rd_en_i | input | 1 | Register read strobe (latches the snapshot at address 5) |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | CW | Register read data, combinational from `rd_addr_i` |
| ovf_o | output | 1 | One-cycle overflow pulse |
| irq_o | output | 1 | Interrupt, OR of enabled status flags |

## Verification
A write or refresh strobe is taken at one rising edge. Its effect on the counter and on the status flags can be read through the combinational read port in the very next cycle. `ovf_o` is high during the cycle after the edge at which the counter reaches the terminal count, and status bit 2 follows one edge later. The bench drives every strobe for exactly one clock and samples outputs on falling edges. A scoreboard entry therefore always refers to a known edge. The counter is kept on a 100-cycle pre-divider whenever exact counter values are compared, so a margin of tens of cycles makes each expected count exact. Overflow periods are measured by counting falling edges between pulses.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [2:0] {
      MODE_DIRECT  = 3'd0,
      MODE_WINDOW  = 3'd1,
      MODE_SEQ     = 3'd2,
      MODE_DIR_SEQ = 3'd3,
      MODE_WIN_SEQ = 3'd4
   } refresh_mode_e;

   localparam int unsigned NUM_FLAGS = 3;
   localparam int unsigned FLAG_WIN  = 0;
   localparam int unsigned FLAG_SEQ  = 1;
   localparam int unsigned FLAG_OVF  = 2;

   localparam int unsigned ADDR_W    = 3;
   localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] REG_DIV   = 3'd1;
   localparam logic [ADDR_W-1:0] REG_TERM  = 3'd2;
   localparam logic [ADDR_W-1:0] REG_WINLO = 3'd3;
   localparam logic [ADDR_W-1:0] REG_DELTA = 3'd4;
   localparam logic [ADDR_W-1:0] REG_STAMP = 3'd5;
   localparam logic [ADDR_W-1:0] REG_IEN   = 3'd6;
   localparam logic [ADDR_W-1:0] REG_STAT  = 3'd7;

   localparam int unsigned CTRL_W = 5;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int unsigned PW      = 16,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          run_i,
   input  logic [PW-1:0] ratio_i,
   input  logic          restart_i,
   output logic          tick_o
);

   generate
      if (HAS_DIV) begin : g_div
         logic [PW-1:0] phase_q;

         assign tick_o = run_i && (phase_q == ratio_i);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               phase_q <= '0;
            end else if (restart_i || !run_i || tick_o) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end
      end else begin : g_nodiv
         assign tick_o = run_i;
      end
   endgenerate

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int unsigned CW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          run_i,
   input  logic          tick_i,
   input  logic          restart_i,
   input  logic          auto_i,
   input  logic [CW-1:0] term_i,
   output logic [CW-1:0] cnt_o,
   output logic          ovf_o
);

   logic [CW-1:0] cnt_q;
   logic          ovf_q;
   logic [CW:0]   nxt_ext;
   logic          parked;

   assign nxt_ext = {1'b0, cnt_q} + 1'b1;
   assign parked  = !auto_i && (cnt_q == term_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= 1'b0;
         if (restart_i) begin
            cnt_q <= '0;
         end else if (run_i && tick_i && !parked) begin
            if (nxt_ext >= {1'b0, term_i}) begin
               ovf_q <= 1'b1;
               cnt_q <= auto_i ? '0 : term_i;
            end else begin
               cnt_q <= nxt_ext[CW-1:0];
            end
         end
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

endmodule

// File: rtl/wdog_refresh_chk.sv
module wdog_refresh_chk
   import wdog_pkg::*;
#(
   parameter int unsigned CW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          run_i,
   input  logic [2:0]    mode_i,
   input  logic          kick_i,
   input  logic          stamp_we_i,
   input  logic [CW-1:0] stamp_i,
   input  logic          snap_re_i,
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] term_i,
   input  logic [CW-1:0] winlo_i,
   input  logic [CW-1:0] delta_i,
   output logic          restart_o,
   output logic          bad_win_o,
   output logic          bad_seq_o
);

   logic [CW-1:0] snap_q;
   logic          snap_vld_q;
   logic          use_win;
   logic          use_seq;
   logic          evt;
   logic          win_ok;
   logic          seq_ok;
   logic [CW-1:0] elapsed;

   always_comb begin
      use_win = 1'b0;
      use_seq = 1'b0;
      case (mode_i)
         MODE_WINDOW:  use_win = 1'b1;
         MODE_SEQ:     use_seq = 1'b1;
         MODE_DIR_SEQ: use_seq = 1'b1;
         MODE_WIN_SEQ: begin
            use_win = 1'b1;
            use_seq = 1'b1;
         end
         default: ;
      endcase
   end

   assign evt     = run_i && (use_seq ? stamp_we_i : kick_i);
   assign elapsed = cnt_i - snap_q;
   assign win_ok  = !use_win || ((cnt_i >= winlo_i) && (cnt_i <= term_i));
   assign seq_ok  = !use_seq ||
                    (snap_vld_q && (stamp_i == snap_q) && (elapsed < delta_i));

   assign restart_o = evt && win_ok && seq_ok;
   assign bad_win_o = evt && !win_ok;
   assign bad_seq_o = evt && !seq_ok;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         snap_q     <= '0;
         snap_vld_q <= 1'b0;
      end else if (snap_re_i) begin
         snap_q     <= cnt_i;
         snap_vld_q <= 1'b1;
      end else if (stamp_we_i) begin
         snap_vld_q <= 1'b0;
      end
   end

endmodule

// File: rtl/wdog_flags.sv
module wdog_flags #(
   parameter int unsigned NF = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [NF-1:0] set_i,
   input  logic [NF-1:0] clr_i,
   input  logic [NF-1:0] ien_i,
   output logic [NF-1:0] sts_o,
   output logic          irq_o
);

   logic [NF-1:0] sts_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sts_q <= '0;
      end else begin
         for (int i = 0; i < NF; i++) begin
            if (set_i[i]) begin
               sts_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
               sts_q[i] <= 1'b0;
            end
         end
      end
   end

   assign sts_o = sts_q;
   assign irq_o = |(sts_q & ien_i);

endmodule

// File: rtl/wdog_seqwin.sv
module wdog_seqwin
   import wdog_pkg::*;
#(
   parameter int unsigned CW      = 32,
   parameter int unsigned PW      = 16,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              kick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [CW-1:0]     wr_data_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [CW-1:0]     rd_data_o,
   output logic              ovf_o,
   output logic              irq_o
);

   localparam int unsigned CTRL_PAD = CW - CTRL_W;
   localparam int unsigned DIV_PAD  = CW - PW;
   localparam int unsigned FLG_PAD  = CW - NUM_FLAGS;

   generate
      if (CW <= PW) begin : g_bad_cw
         $error("wdog_seqwin: CW must exceed PW");
      end
      if (CW < 8) begin : g_bad_min
         $error("wdog_seqwin: CW must be at least 8");
      end
   endgenerate

   logic                 run_q;
   logic                 auto_q;
   logic [2:0]           mode_q;
   logic [PW-1:0]        ratio_q;
   logic [CW-1:0]        term_q;
   logic [CW-1:0]        winlo_q;
   logic [CW-1:0]        delta_q;
   logic [NUM_FLAGS-1:0] ien_q;
   logic [NUM_FLAGS-1:0] sts_q;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_clr;
   logic [CW-1:0]        cnt_q;
   logic                 tick;
   logic                 restart;
   logic                 bad_win;
   logic                 bad_seq;
   logic                 stamp_we;
   logic                 snap_re;

   function automatic logic wr_hit(input logic [ADDR_W-1:0] a);
      return wr_en_i && (wr_addr_i == a);
   endfunction

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= 1'b0;
         auto_q  <= 1'b0;
         mode_q  <= MODE_DIRECT;
         ratio_q <= '0;
         term_q  <= '0;
         winlo_q <= '0;
         delta_q <= '0;
         ien_q   <= '0;
      end else begin
         if (wr_hit(REG_CTRL)) begin
            run_q  <= wr_data_i[0];
            auto_q <= wr_data_i[1];
            mode_q <= wr_data_i[4:2];
         end
         if (wr_hit(REG_DIV))   ratio_q <= wr_data_i[PW-1:0];
         if (wr_hit(REG_TERM))  term_q  <= wr_data_i;
         if (wr_hit(REG_WINLO)) winlo_q <= wr_data_i;
         if (wr_hit(REG_DELTA)) delta_q <= wr_data_i;
         if (wr_hit(REG_IEN))   ien_q   <= wr_data_i[NUM_FLAGS-1:0];
      end
   end

   assign stamp_we = wr_hit(REG_STAMP);
   assign snap_re  = rd_en_i && (rd_addr_i == REG_STAMP);
   assign flag_clr = wr_hit(REG_STAT) ? wr_data_i[NUM_FLAGS-1:0] : '0;

   always_comb begin
      flag_set           = '0;
      flag_set[FLAG_WIN] = bad_win;
      flag_set[FLAG_SEQ] = bad_seq;
      flag_set[FLAG_OVF] = ovf_o;
   end

   wdog_prescale #(.PW(PW), .HAS_DIV(HAS_DIV)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_q),
      .ratio_i   (ratio_q),
      .restart_i (restart),
      .tick_o    (tick)
   );

   wdog_count #(.CW(CW)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_q),
      .tick_i    (tick),
      .restart_i (restart),
      .auto_i    (auto_q),
      .term_i    (term_q),
      .cnt_o     (cnt_q),
      .ovf_o     (ovf_o)
   );

   wdog_refresh_chk #(.CW(CW)) u_chk_ref (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_q),
      .mode_i     (mode_q),
      .kick_i     (kick_i),
      .stamp_we_i (stamp_we),
      .stamp_i    (wr_data_i),
      .snap_re_i  (snap_re),
      .cnt_i      (cnt_q),
      .term_i     (term_q),
      .winlo_i    (winlo_q),
      .delta_i    (delta_q),
      .restart_o  (restart),
      .bad_win_o  (bad_win),
      .bad_seq_o  (bad_seq)
   );

   wdog_flags #(.NF(NUM_FLAGS)) u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set),
      .clr_i  (flag_clr),
      .ien_i  (ien_q),
      .sts_o  (sts_q),
      .irq_o  (irq_o)
   );

   always_comb begin
      case (rd_addr_i)
         REG_CTRL:  rd_data_o = {{CTRL_PAD{1'b0}}, mode_q, auto_q, run_q};
         REG_DIV:   rd_data_o = {{DIV_PAD{1'b0}}, ratio_q};
         REG_TERM:  rd_data_o = term_q;
         REG_WINLO: rd_data_o = winlo_q;
         REG_DELTA: rd_data_o = delta_q;
         REG_STAMP: rd_data_o = cnt_q;
         REG_IEN:   rd_data_o = {{FLG_PAD{1'b0}}, ien_q};
         default:   rd_data_o = {{FLG_PAD{1'b0}}, sts_q};
      endcase
   end

endmodule

// File: rtl/wdog_seqwin_chk.sv
module wdog_seqwin_chk
   import wdog_pkg::*;
#(
   parameter int unsigned CW = 32
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 kick_i,
   input logic                 wr_en_i,
   input logic [ADDR_W-1:0]    wr_addr_i,
   input logic [CW-1:0]        wr_data_i,
   input logic                 ovf_o,
   input logic                 run_q,
   input logic                 auto_q,
   input logic [2:0]           mode_q,
   input logic [CW-1:0]        cnt_q,
   input logic [CW-1:0]        term_q,
   input logic [NUM_FLAGS-1:0] sts_q,
   input logic                 restart,
   input logic                 bad_seq
);

   // R2: the counter moves only by one step, back to zero, or onto the terminal count
   a_r2_step_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cnt_q) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)
                           || (cnt_q == $past(term_q))));

   // R3: an overflow pulse leaves the overflow flag set
   a_r3_ovf_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |=> sts_q[FLAG_OVF]);

   // R4: a parked counter stays put until a refresh
   a_r4_hold_at_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && !auto_q && (cnt_q == term_q) && !restart) |=> (cnt_q == $past(cnt_q)));

   // R5: a direct-mode kick clears the counter
   a_r5_kick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && (mode_q == MODE_DIRECT) && kick_i) |=> (cnt_q == '0));

   // R9: a rejected sequence refresh leaves the sequence flag set
   a_r9_seq_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_seq |=> sts_q[FLAG_SEQ]);

   // R12: the window flag is sticky unless a one is written to it
   a_r12_sticky_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_q[FLAG_WIN] && !(wr_en_i && (wr_addr_i == REG_STAT) && wr_data_i[FLAG_WIN]))
      |=> sts_q[FLAG_WIN]);

endmodule

bind wdog_seqwin wdog_seqwin_chk #(.CW(CW)) u_wdog_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .kick_i    (kick_i),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i),
   .wr_data_i (wr_data_i),
   .ovf_o     (ovf_o),
   .run_q     (run_q),
   .auto_q    (auto_q),
   .mode_q    (mode_q),
   .cnt_q     (cnt_q),
   .term_q    (term_q),
   .sts_q     (sts_q),
   .restart   (restart),
   .bad_seq   (bad_seq)
);

// File: tb/wdog_seqwin_tb_top.sv
module wdog_seqwin_tb_top;

   localparam logic [2:0] A_CTRL = 3'd0, A_DIV = 3'd1, A_TERM = 3'd2, A_WINLO = 3'd3,
                          A_DELTA = 3'd4, A_STAMP = 3'd5, A_IEN = 3'd6, A_STAT = 3'd7;

   typedef struct {
      string       req;
      logic [31:0] val;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        kick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        ovf;
   logic        irq;

   int   n_chk = 0;
   int   n_fail = 0;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   wdog_seqwin dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .kick_i    (kick),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_en_i   (rd_en),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .ovf_o     (ovf),
      .irq_o     (irq)
   );

   // scoreboard monitor: compares each scheduled read against its expected item
   always begin : mon
      exp_t e;
      @(negedge clk);
      #1;
      if (rd_en && sb_q.size() > 0) begin
         e = sb_q.pop_front();
         n_chk++;
         if (rd_data !== e.val)
            $display("FAIL %s: read addr %0d got %0d expected %0d", e.req, rd_addr, rd_data, e.val);
         if (rd_data !== e.val) n_fail++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic kick_once();
      @(negedge clk);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
   endtask

   task automatic rd_exp(input logic [2:0] a, input logic [31:0] v, input string req);
      exp_t e;
      e.req = req;
      e.val = v;
      sb_q.push_back(e);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_get(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      #1 v = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ovf_gap(output int gap);
      int c = 0;
      do @(negedge clk); while (!ovf);
      do begin @(negedge clk); c++; end while (!ovf);
      gap = c;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin : driver
      int          gap;
      int          pulses;
      logic [31:0] v;

      idle(4);
      // R1: reset state
      check("R1 ovf", {31'd0, ovf}, 32'd0);
      check("R1 irq", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      rd_exp(A_CTRL, 0, "R1 ctrl");
      rd_exp(A_STAT, 0, "R1 status");
      rd_exp(A_STAMP, 0, "R1 counter");

      // R3: auto-restart period, ratio 0
      wr(A_TERM, 10);
      wr(A_CTRL, 32'h3);
      ovf_gap(gap);
      check("R3 period ratio0", gap, 10);
      rd_exp(A_STAT, 4, "R3 overflow flag");
      check("R12 irq masked", {31'd0, irq}, 32'd0);

      // R2: ratio 1 doubles the period
      wr(A_DIV, 1);
      ovf_gap(gap);
      ovf_gap(gap);
      check("R2 period ratio1", gap, 20);

      // R4: hold mode
      wr(A_DIV, 0);
      wr(A_CTRL, 32'h1);
      idle(30);
      pulses = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (ovf) pulses++;
      end
      check("R4 no further pulses", pulses, 0);
      rd_exp(A_STAMP, 10, "R4 parked at terminal");

      // R12: enable and write-one-to-clear
      wr(A_IEN, 4);
      check("R12 irq enabled", {31'd0, irq}, 32'd1);
      rd_exp(A_STAT, 4, "R12 sticky");
      wr(A_STAT, 4);
      rd_exp(A_STAT, 0, "R12 cleared");
      check("R12 irq after clear", {31'd0, irq}, 32'd0);

      // R5: direct kicks, slow counter
      wr(A_DIV, 99);
      kick_once();
      rd_exp(A_STAMP, 0, "R5 kick from parked");
      idle(250);
      rd_exp(A_STAMP, 2, "R2 R7 slow count");
      kick_once();
      rd_exp(A_STAMP, 0, "R5 kick restarts");

      // R6: window mode
      wr(A_WINLO, 5);
      wr(A_CTRL, 32'h5);
      idle(150);
      kick_once();
      rd_exp(A_STAT, 1, "R6 early kick flag");
      rd_exp(A_STAMP, 1, "R6 early kick keeps count");
      idle(450);
      kick_once();
      rd_exp(A_STAMP, 0, "R6 late kick restarts");
      rd_exp(A_STAT, 1, "R12 window flag sticky");
      wr(A_STAT, 1);
      rd_exp(A_STAT, 0, "R12 window flag cleared");

      // R8: sequence mode
      wr(A_TERM, 1000);
      wr(A_DELTA, 3);
      wr(A_CTRL, 32'h9);
      rd_get(A_STAMP, v);
      wr(A_STAMP, v);
      rd_exp(A_STAMP, 0, "R8 echo restarts");
      rd_exp(A_STAT, 0, "R8 no flag");
      idle(250);
      kick_once();
      rd_exp(A_STAMP, 2, "R8 kick ignored");

      // R9: mismatch
      wr(A_STAMP, 3);
      rd_exp(A_STAT, 2, "R9 mismatch flag");
      rd_exp(A_STAMP, 2, "R9 mismatch keeps count");
      wr(A_STAT, 2);
      wr(A_STAMP, 2);
      rd_exp(A_STAMP, 0, "R8 matching echo");

      // R10: delta boundary
      rd_get(A_STAMP, v);
      idle(250);
      wr(A_STAMP, v);
      rd_exp(A_STAMP, 0, "R10 delta minus one legal");
      rd_get(A_STAMP, v);
      idle(350);
      wr(A_STAMP, v);
      rd_exp(A_STAT, 2, "R10 late echo flag");
      rd_exp(A_STAMP, 3, "R10 late echo keeps count");
      wr(A_STAT, 2);

      // R11: combined modes
      wr(A_CTRL, 32'h11);
      wr(A_STAMP, 3);
      rd_exp(A_STAT, 1, "R11 mode4 window only flag");
      rd_exp(A_STAMP, 3, "R11 mode4 keeps count");
      wr(A_STAT, 1);
      wr(A_CTRL, 32'hD);
      wr(A_STAMP, 3);
      rd_exp(A_STAMP, 0, "R11 mode3 no window check");
      rd_exp(A_STAT, 0, "R11 mode3 no flag");

      while (sb_q.size() > 0) @(negedge clk);
      idle(2);
      finish_run();
   end

endmodule